// File: doc/BRIEF.md
# Table-Driven High-Voltage Sweep DAC Sequencer

This block moves two high-voltage sweep DACs through a voltage pattern that is stored in an on-chip table of 16-bit words. Each rising edge of the accumulation-interval strobe starts one sweep step, but only while the sweep is enabled. In a step, the block reads the current entry from the region of sweep DAC A and from the region of sweep DAC B. It shifts each word out to its DAC and then moves the step index on. A sweep has 32 steps, and four sweeps fit into one second.

Once a second, on the sync tick, the block also reloads the bias DAC and the test-pulser DAC from their command-register values. The command block fills the table through a write port. That port is locked while the sweep runs. All four DACs share one serial clock line, one data line and one clear line. Each DAC has its own load strobe.

Top module: `sweep_dac_seq`

## Requirements
- R1: While reset is held, `dac_ld_o` is 0, `dac_sck_o` is low and `tbl_raddr_o` is 0. `dac_clr_o` is high during reset and falls at the first clock edge after reset is released. After that it stays low.
- R2: Each DAC word is 16 bits and is sent MSB first. `dac_sdo_o` is set while `dac_sck_o` is low, and a DAC samples it on the rising edge of `dac_sck_o`. After the 16th bit, exactly one `dac_ld_o` bit pulses for one cycle, with `dac_sck_o` low. The load bit mapping is: bit 0 is sweep DAC A, bit 1 is sweep DAC B, bit 2 is bias, bit 3 is test pulser.
- R3: A rising edge of `accum_i` while `sweep_en_i` is high starts one step. Sweep DAC A is loaded with table entry `idx`, and then sweep DAC B is loaded with entry `32 + idx`. After that, `idx` advances by one.
- R4: The step index wraps from 31 back to 0, so step 33 loads the same words as step 1.
- R5: A step is started by the edge of `accum_i`, not its level. Holding the strobe high starts exactly one step, and a strobe that arrives while the sweep is disabled starts none.
- R6: A one-cycle `sync_i` tick loads the bias DAC with `bias_val_i` and then the test-pulser DAC with `tpul_val_i`, whether or not the sweep is enabled.
- R7: If a step and a sync tick are pending together, both sweep words are sent before the two fixed words, and none of the four is dropped.
- R8: A table write (`tbl_we_i` high) stores `tbl_wdata_i` at `tbl_waddr_i` only while `sweep_en_i` is low. While the sweep is enabled, a write has no effect.
- R9: If `sweep_en_i` drops during a step, the serial transfer already in progress finishes with its load pulse. The rest of the step is abandoned and the block goes idle with `idx` unchanged, so the next step reloads the same entry.
- R10: `tbl_raddr_o` holds the table address of the most recent sweep read, which is `32 + idx` once a complete step has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sweep_en_i | input | 1 | Sweep enable; also write-locks the table |
| accum_i | input | 1 | Accumulation-interval strobe (rising edge used) |
| sync_i | input | 1 | One-second tick, one cycle wide |
| bias_val_i | input | 16 | Bias DAC command value |
| tpul_val_i | input | 16 | Test-pulser DAC command value |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_waddr_i | input | 8 | Table write address |
| tbl_wdata_i | input | 16 | Table write data |
| tbl_raddr_o | output | 8 | Current table read address |
| dac_sck_o | output | 1 | Shared DAC serial clock |
| dac_sdo_o | output | 1 | Shared DAC serial data, MSB first |
| dac_clr_o | output | 1 | Shared DAC clear |
| dac_ld_o | output | 4 | Per-DAC load strobes |

## Verification
The assertions assume three things about the inputs:
- `sync_i` is a single-cycle tick that does not repeat within one fixed-DAC refresh.
- `accum_i` edges are spaced further apart than one full step.
- The serializer is never started while it is busy, which the controller itself guarantees.

The stimulus waits long enough after every strobe and tick for the whole transfer to finish. The only deliberate overlaps are the cases that test the required behaviour: the simultaneous tick and strobe, the strobe held high, and the enable dropped partway through a transfer.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [1:0] {CS_IDLE, CS_RD, CS_LD, CS_DONE} ctl_state_e;
  typedef enum logic {JOB_STEP, JOB_FIX} job_kind_e;
  typedef enum logic [1:0] {SH_IDLE, SH_BIT, SH_LOAD} sh_state_e;
  localparam int unsigned N_DAC = 4;
  localparam logic [1:0] DAC_SWA  = 2'd0;
  localparam logic [1:0] DAC_SWB  = 2'd1;
  localparam logic [1:0] DAC_BIAS = 2'd2;
  localparam logic [1:0] DAC_TPUL = 2'd3;
endpackage

// File: rtl/sweep_lut.sv
module sweep_lut #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          lock_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && !lock_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem_q[raddr_i];
  end

  AST_WR_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lock_i) |=> (mem_q[$past(waddr_i)] == $past(mem_q[waddr_i]))); // R8
endmodule

// File: rtl/sweep_dac_shift.sv
module sweep_dac_shift
  import sweep_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned ND   = 4,
  localparam int unsigned CW  = $clog2(DW),
  localparam int unsigned SW  = $clog2(ND)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] word_i,
  input  logic [SW-1:0] sel_i,
  output logic          sck_o,
  output logic          sdo_o,
  output logic [ND-1:0] ld_o,
  output logic          done_o
);
  sh_state_e     st_q;
  logic [DW-1:0] sr_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] sel_q;
  logic          busy;

  assign busy  = (st_q != SH_IDLE);
  assign sdo_o = sr_q[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SH_IDLE;
      sr_q   <= '0;
      cnt_q  <= '0;
      sel_q  <= '0;
      sck_o  <= 1'b0;
      ld_o   <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        SH_IDLE: if (start_i) begin
          sr_q  <= word_i;
          sel_q <= sel_i;
          cnt_q <= '0;
          st_q  <= SH_BIT;
        end
        SH_BIT: begin
          if (!sck_o) sck_o <= 1'b1;
          else begin
            sck_o <= 1'b0;
            sr_q  <= {sr_q[DW-2:0], 1'b0};
            if (cnt_q == CW'(DW-1)) begin
              st_q <= SH_LOAD;
              ld_o <= ND'(1) << sel_q;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        SH_LOAD: begin
          ld_o   <= '0;
          done_o <= 1'b1;
          st_q   <= SH_IDLE;
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end

  AST_LD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ld_o)); // R2
  AST_SCK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !sck_o); // R2
  AST_LD_SCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_o != '0) |-> !sck_o); // R2
  AST_DONE_AFTER_LD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_o != '0) |=> done_o); // R2
  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy); // R2
endmodule

// File: rtl/sweep_ctl.sv
module sweep_ctl
  import sweep_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 8,
  parameter int unsigned STEPS = 32,
  localparam int unsigned IW   = $clog2(STEPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sweep_en_i,
  input  logic          accum_i,
  input  logic          sync_i,
  input  logic [DW-1:0] bias_i,
  input  logic [DW-1:0] tpul_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          done_i,
  output logic [AW-1:0] raddr_o,
  output logic          start_o,
  output logic [DW-1:0] word_o,
  output logic [1:0]    sel_o
);
  ctl_state_e st_q;
  job_kind_e  kind_q;
  logic       job_q, launched_q, accum_q, step_pend_q, fix_pend_q;
  logic [IW-1:0] idx_q;
  logic       step_rise;

  assign step_rise = accum_i & ~accum_q;
  assign start_o   = (st_q == CS_LD) && !launched_q;
  assign word_o    = (kind_q == JOB_STEP) ? rdata_i : (job_q ? tpul_i : bias_i);
  assign sel_o     = (kind_q == JOB_STEP) ? (job_q ? DAC_SWB : DAC_SWA)
                                          : (job_q ? DAC_TPUL : DAC_BIAS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= CS_IDLE;
      kind_q      <= JOB_STEP;
      job_q       <= 1'b0;
      launched_q  <= 1'b0;
      accum_q     <= 1'b0;
      step_pend_q <= 1'b0;
      fix_pend_q  <= 1'b0;
      idx_q       <= '0;
      raddr_o     <= '0;
    end else begin
      accum_q <= accum_i;
      unique case (st_q)
        CS_IDLE: begin
          job_q <= 1'b0;
          if (step_pend_q && sweep_en_i) begin
            kind_q      <= JOB_STEP;
            raddr_o     <= AW'(idx_q);
            step_pend_q <= 1'b0;
            st_q        <= CS_RD;
          end else if (fix_pend_q) begin
            kind_q     <= JOB_FIX;
            fix_pend_q <= 1'b0;
            st_q       <= CS_LD;
          end
        end
        CS_RD: st_q <= sweep_en_i ? CS_LD : CS_IDLE;
        CS_LD: begin
          if (!launched_q) launched_q <= 1'b1;
          if (done_i) begin
            launched_q <= 1'b0;
            if (!job_q && (kind_q == JOB_FIX || sweep_en_i)) begin
              job_q <= 1'b1;
              if (kind_q == JOB_STEP) begin
                raddr_o <= AW'(STEPS) + AW'(idx_q);
                st_q    <= CS_RD;
              end
            end else if (kind_q == JOB_STEP && !sweep_en_i) st_q <= CS_IDLE;
            else st_q <= CS_DONE;
          end
        end
        CS_DONE: begin
          if (kind_q == JOB_STEP)
            idx_q <= (idx_q == IW'(STEPS-1)) ? '0 : idx_q + 1'b1;
          st_q <= CS_IDLE;
        end
        default: st_q <= CS_IDLE;
      endcase
      // new events take priority over the clear on acceptance
      if (!sweep_en_i)    step_pend_q <= 1'b0;
      else if (step_rise) step_pend_q <= 1'b1;
      if (sync_i) fix_pend_q <= 1'b1;
    end
  end

  AST_STEP_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CS_IDLE && step_pend_q && sweep_en_i && fix_pend_q)
      |=> (st_q == CS_RD && kind_q == JOB_STEP && fix_pend_q)); // R7
  AST_NO_STEP_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sweep_en_i && st_q == CS_IDLE) |=> (st_q != CS_RD)); // R5
  AST_RADDR_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CS_RD) |-> (raddr_o < AW'(2*STEPS))); // R3
endmodule

// File: rtl/sweep_dac_seq.sv
module sweep_dac_seq
  import sweep_pkg::*;
#(
  parameter int unsigned DW        = 16,
  parameter int unsigned TBL_DEPTH = 256,
  parameter int unsigned STEPS     = 32,
  localparam int unsigned AW       = $clog2(TBL_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sweep_en_i,
  input  logic             accum_i,
  input  logic             sync_i,
  input  logic [DW-1:0]    bias_val_i,
  input  logic [DW-1:0]    tpul_val_i,
  input  logic             tbl_we_i,
  input  logic [AW-1:0]    tbl_waddr_i,
  input  logic [DW-1:0]    tbl_wdata_i,
  output logic [AW-1:0]    tbl_raddr_o,
  output logic             dac_sck_o,
  output logic             dac_sdo_o,
  output logic             dac_clr_o,
  output logic [N_DAC-1:0] dac_ld_o
);
  logic [DW-1:0] rdata, word;
  logic          start, done;
  logic [1:0]    sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dac_clr_o <= 1'b1;
    else         dac_clr_o <= 1'b0;
  end

  sweep_lut #(.DW(DW), .DEPTH(TBL_DEPTH)) u_lut (
    .clk_i, .rst_ni, .we_i(tbl_we_i), .lock_i(sweep_en_i),
    .waddr_i(tbl_waddr_i), .wdata_i(tbl_wdata_i),
    .raddr_i(tbl_raddr_o), .rdata_o(rdata)
  );

  sweep_ctl #(.DW(DW), .AW(AW), .STEPS(STEPS)) u_ctl (
    .clk_i, .rst_ni, .sweep_en_i, .accum_i, .sync_i,
    .bias_i(bias_val_i), .tpul_i(tpul_val_i), .rdata_i(rdata),
    .done_i(done), .raddr_o(tbl_raddr_o), .start_o(start),
    .word_o(word), .sel_o(sel)
  );

  sweep_dac_shift #(.DW(DW), .ND(N_DAC)) u_shift (
    .clk_i, .rst_ni, .start_i(start), .word_i(word), .sel_i(sel),
    .sck_o(dac_sck_o), .sdo_o(dac_sdo_o), .ld_o(dac_ld_o), .done_o(done)
  );

  AST_CLR_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_clr_o |=> !dac_clr_o); // R1
endmodule

// File: tb/sim_sweep_dac_seq.sv
`timescale 1ns/1ps
module sim_sweep_dac_seq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sweep_en = 1'b0, accum = 1'b0, sync_t = 1'b0;
  logic [15:0] bias_v = '0, tpul_v = '0;
  logic        we = 1'b0;
  logic [7:0]  waddr = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  raddr;
  logic        sck, sdo, clr;
  logic [3:0]  ld;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sweep_dac_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sweep_en_i(sweep_en), .accum_i(accum),
    .sync_i(sync_t), .bias_val_i(bias_v), .tpul_val_i(tpul_v),
    .tbl_we_i(we), .tbl_waddr_i(waddr), .tbl_wdata_i(wdata),
    .tbl_raddr_o(raddr), .dac_sck_o(sck), .dac_sdo_o(sdo),
    .dac_clr_o(clr), .dac_ld_o(ld)
  );

  // behavioural DAC receivers
  logic [15:0] rx_sr = '0;
  logic [15:0] rx_val [4];
  int ld_cnt [4];
  int ord [8];
  int ord_n = 0, multi_ld = 0, ld_sck_hi = 0;

  initial for (int k = 0; k < 4; k++) begin rx_val[k] = '0; ld_cnt[k] = 0; end

  always @(posedge sck) rx_sr = {rx_sr[14:0], sdo};

  always @(negedge clk) begin
    if (clr) for (int k = 0; k < 4; k++) rx_val[k] = '0;
    for (int k = 0; k < 4; k++) if (ld[k]) begin
      rx_val[k] = rx_sr;
      ld_cnt[k]++;
      if (ord_n < 8) begin ord[ord_n] = k; ord_n++; end
    end
    if ($countones(ld) > 1) multi_ld++;
    if (ld != 0 && sck) ld_sck_hi++;
  end

  function automatic logic [15:0] tval(int i);
    return 16'h5A00 ^ 16'(i * 257);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tbl_write(logic [7:0] a, logic [15:0] d);
    we = 1'b1; waddr = a; wdata = d;
    cyc(1);
    we = 1'b0;
  endtask

  task automatic strobe(int hold);
    accum = 1'b1;
    cyc(hold);
    accum = 1'b0;
  endtask

  task automatic tick();
    sync_t = 1'b1;
    cyc(1);
    sync_t = 1'b0;
  endtask

  // {bias, test pulser} stimulus; the same words are expected in the DACs
  localparam logic [31:0] FIX_VEC [4] = '{
    32'h8001_7FFE, 32'h1234_ABCD, 32'hFFFF_0000, 32'h0F0F_C3A5
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int idx;
    int c0, c1;
    idx = 0;
    cyc(3);
    chk("R1 clr in reset", 32'(clr), 32'd1);
    chk("R1 ld in reset", 32'(ld), 32'd0);
    chk("R1 sck in reset", 32'(sck), 32'd0);
    chk("R1 raddr in reset", 32'(raddr), 32'd0);
    rst_ni = 1'b1;
    cyc(1);
    chk("R1 clr after first edge", 32'(clr), 32'd0);
    cyc(5);
    chk("R1 clr stays low", 32'(clr), 32'd0);

    // R8: table loaded while sweep disabled
    for (int i = 0; i < 64; i++) tbl_write(8'(i), tval(i));

    // R6 / R2: fixed-DAC refresh vectors
    for (int v = 0; v < 4; v++) begin
      bias_v = FIX_VEC[v][31:16];
      tpul_v = FIX_VEC[v][15:0];
      tick();
      cyc(100);
      chk("R6 R2 bias word", 32'(rx_val[2]), 32'(FIX_VEC[v][31:16]));
      chk("R6 R2 tpul word", 32'(rx_val[3]), 32'(FIX_VEC[v][15:0]));
    end

    // R3 / R4 / R10: 34 steps, crossing the wrap
    sweep_en = 1'b1;
    cyc(2);
    for (int s = 0; s < 34; s++) begin
      strobe(2);
      cyc(120);
      chk(s < 32 ? "R3 sweep A word" : "R4 wrap sweep A word", 32'(rx_val[0]), 32'(tval(idx)));
      chk(s < 32 ? "R3 sweep B word" : "R4 wrap sweep B word", 32'(rx_val[1]), 32'(tval(32 + idx)));
      chk("R10 read address", 32'(raddr), 32'(32 + idx));
      idx = (idx + 1) % 32;
    end

    // R5: level held long gives one step
    c0 = ld_cnt[0];
    strobe(150);
    cyc(120);
    chk("R5 one step per edge", 32'(ld_cnt[0] - c0), 32'd1);
    chk("R5 held strobe word", 32'(rx_val[0]), 32'(tval(idx)));
    idx = (idx + 1) % 32;

    // R8: write while enabled ignored
    tbl_write(8'(idx), 16'hFFFF);
    strobe(2);
    cyc(120);
    chk("R8 locked write ignored", 32'(rx_val[0]), 32'(tval(idx)));
    idx = (idx + 1) % 32;

    // R7: simultaneous strobe and tick
    bias_v = 16'h2468; tpul_v = 16'h1357;
    ord_n = 0;
    accum = 1'b1; sync_t = 1'b1;
    cyc(1);
    sync_t = 1'b0;
    cyc(1);
    accum = 1'b0;
    cyc(250);
    chk("R7 load count", 32'(ord_n), 32'd4);
    for (int k = 0; k < 4; k++) chk("R7 load order", 32'(ord[k]), 32'(k));
    chk("R7 bias kept", 32'(rx_val[2]), 32'h2468);
    chk("R7 sweep A", 32'(rx_val[0]), 32'(tval(idx)));
    idx = (idx + 1) % 32;

    // R9: disable during sweep A transfer
    c1 = ld_cnt[1];
    accum = 1'b1;
    cyc(10);
    sweep_en = 1'b0;
    accum = 1'b0;
    cyc(120);
    chk("R9 A transfer completed", 32'(rx_val[0]), 32'(tval(idx)));
    chk("R9 B not loaded", 32'(ld_cnt[1] - c1), 32'd0);
    chk("R9 B holds old word", 32'(rx_val[1]), 32'(tval(32 + (idx + 31) % 32)));

    // R5: strobe while disabled starts nothing
    c0 = ld_cnt[0];
    strobe(2);
    cyc(120);
    chk("R5 disabled strobe ignored", 32'(ld_cnt[0] - c0), 32'd0);

    // R9: index held, same entry reloaded
    sweep_en = 1'b1;
    cyc(2);
    strobe(2);
    cyc(120);
    chk("R9 same entry A", 32'(rx_val[0]), 32'(tval(idx)));
    chk("R9 same entry B", 32'(rx_val[1]), 32'(tval(32 + idx)));

    chk("R2 single load line", 32'(multi_ld), 32'd0);
    chk("R2 load with sck low", 32'(ld_sck_hi), 32'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule